// File: doc/BRIEF.md
# Miss-Pattern Phase Boundary Detector

This block scans a run of program intervals, each a span of 100,000 executed instructions, and marks the interval starts where two candidate cache configurations stop behaving alike. Every record on its input holds the miss count of each configuration for one interval. The counts are already normalized, so that each configuration's total over the whole run is the same constant. The magnitude of the difference between the two counts is the interval's profitability. An interval whose profitability is above a programmable threshold is a candidate reconfiguration point. A change in miss behaviour that both configurations show in the same measure gives a profitability near zero, and so gives no point.

Accepted points must be at least `SPACING` intervals apart. The default is five intervals, which is 500,000 instructions. The first eligible candidate opens a selection window of `SPACING` intervals. When the window closes, or when the stream ends, the most profitable candidate in the window is emitted. After that, candidates closer than `SPACING` intervals to the emitted point are ignored. Each emitted point carries its interval index within the run and its profitability.

Top module: `phase_boundary_detect`

## Requirements
- R1: After a synchronous active-low reset, `pt_valid` is low and remains low until a record closes a selection window.
- R2: The profitability of a record is |`rec_miss_a` − `rec_miss_b`| (unsigned 16-bit), and an emitted point reports the profitability of its interval on `pt_profit`.
- R3: A record is a candidate only when its profitability is strictly greater than `thresh`. Equal miss counts, or a profitability equal to `thresh`, never produce a point.
- R4: `pt_index` is the zero-based position of the chosen interval among the valid records of the current run. The first record after reset, or after a record with `rec_last` set, has index 0.
- R5: A point is reported as a one-cycle pulse on `pt_valid`, in the clock cycle that follows the edge at which the record closing the window is accepted.
- R6: A window opens at the first eligible candidate and spans `SPACING` consecutive intervals, the opening one included. The emitted point is the candidate in the window with the highest profitability. On a tie, the earliest interval wins.
- R7: After a point at index p, a new window can open only at a candidate whose index is at least p + `SPACING`. Candidates before that index are ignored.
- R8: A record with `rec_last` set closes any open window, including one that this record opens, and emits the window's best point. It then clears the spacing history, so that the next run starts without any constraint.
- R9: Cycles with `rec_valid` low have no effect. The interval index does not advance, and no point is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rec_valid | input | 1 | An interval record is present this cycle |
| rec_miss_a | input | CNT_W | Normalized miss count, configuration A |
| rec_miss_b | input | CNT_W | Normalized miss count, configuration B |
| rec_last | input | 1 | This record is the final interval of the run |
| thresh | input | CNT_W | Profitability threshold (strict) |
| pt_valid | output | 1 | A reconfiguration point is reported this cycle |
| pt_index | output | IDX_W | Interval index of the reported point |
| pt_profit | output | CNT_W | Profitability of the reported point |

## Verification
Directed streams exercise the following cases:
- counts that are equal but large, which separate a true divergence from a common change in miss behaviour;
- profitabilities one below, at and one above the threshold, which pin down the strict comparison;
- windows with rising values, falling values and ties, which expose the choice of the best candidate and the earliest-wins rule;
- a candidate just after a window closes, which shows whether spacing is measured from the emitted index;
- streams that end mid-window, or on a lone candidate, and are then restarted, which test the end-of-run flush and the index restart.

A sweep over three thresholds follows. It feeds pseudo-random 4-bit counts with idle gaps and compares every cycle against an arithmetic model, so that many overlapping window and spacing cases are covered.

// File: rtl/pbd_pkg.sv
// Package: shared types and helpers for the phase boundary detector.
// Assumes all counts are unsigned.
package pbd_pkg;

    // Selection window state
    typedef enum logic {
        WIN_IDLE = 1'b0,
        WIN_OPEN = 1'b1
    } win_state_t;

endpackage

// File: rtl/pbd_absdiff.sv
// Module: pbd_absdiff
// Computes the magnitude of the difference of two normalized miss counts
// and flags a candidate when it strictly exceeds the threshold.
// Assumes both counts share the same normalization; purely combinational.
module pbd_absdiff #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt_a,
    input  logic [CNT_W-1:0] cnt_b,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] magnitude,
    output logic             over
);

    // Subtract the smaller count from the larger one
    always_comb begin
        if (cnt_a >= cnt_b) begin
            magnitude = cnt_a - cnt_b;
        end else begin
            magnitude = cnt_b - cnt_a;
        end
        over = (magnitude > limit);
    end

endmodule

// File: rtl/pbd_interval_ctr.sv
// Module: pbd_interval_ctr
// Tracks the zero-based index of the current interval record in a run.
// Assumes that one valid record is one interval and that the last record
// of a run restarts the count at zero.
module pbd_interval_ctr #(
    parameter int IDX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             restart,
    output logic [IDX_W-1:0] cur_idx
);

    logic [IDX_W-1:0] idx_q;

    // Advance on each accepted record; return to zero at end of run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (step) begin
            if (restart) begin
                idx_q <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign cur_idx = idx_q;

endmodule

// File: rtl/pbd_window_sel.sv
// Module: pbd_window_sel
// Opens a window of SPACING intervals at the first eligible candidate,
// keeps the most profitable candidate inside it (the earliest on a tie),
// emits that candidate when the window closes or the run ends, and then
// blocks candidates closer than SPACING intervals to the emitted point.
// Assumes indices stay monotonic within a run; outputs are registered.
module pbd_window_sel
    import pbd_pkg::*;
#(
    parameter int IDX_W   = 16,
    parameter int CNT_W   = 16,
    parameter int SPACING = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic [IDX_W-1:0] in_idx,
    input  logic [CNT_W-1:0] in_profit,
    input  logic             in_hit,
    output logic             out_valid,
    output logic [IDX_W-1:0] out_idx,
    output logic [CNT_W-1:0] out_profit
);

    localparam logic [IDX_W-1:0] SPAN     = IDX_W'(SPACING);
    localparam logic [IDX_W-1:0] SPAN_M1  = IDX_W'(SPACING - 1);

    win_state_t       state_q, state_d;
    logic [IDX_W-1:0] end_q, end_d;
    logic [IDX_W-1:0] best_idx_q, best_idx_d;
    logic [CNT_W-1:0] best_prof_q, best_prof_d;
    logic             have_prev_q, have_prev_d;
    logic [IDX_W-1:0] prev_idx_q, prev_idx_d;
    logic             eligible;
    logic             emit;
    logic             out_valid_q;
    logic [IDX_W-1:0] out_idx_q;
    logic [CNT_W-1:0] out_profit_q;

    // A candidate may open a window only when it is far enough from the last point
    always_comb begin
        eligible = in_hit && (!have_prev_q || ((in_idx - prev_idx_q) >= SPAN));
    end

    // Next-state logic for the window, the best candidate and the spacing history
    always_comb begin
        state_d     = state_q;
        end_d       = end_q;
        best_idx_d  = best_idx_q;
        best_prof_d = best_prof_q;
        have_prev_d = have_prev_q;
        prev_idx_d  = prev_idx_q;
        emit        = 1'b0;
        if (in_valid) begin
            if (state_q == WIN_IDLE) begin
                if (eligible) begin
                    state_d     = WIN_OPEN;
                    end_d       = in_idx + SPAN_M1;
                    best_idx_d  = in_idx;
                    best_prof_d = in_profit;
                end
            end else if (in_hit && (in_profit > best_prof_q)) begin
                best_idx_d  = in_idx;
                best_prof_d = in_profit;
            end
            if ((state_d == WIN_OPEN) && (in_last || (in_idx == end_d))) begin
                emit        = 1'b1;
                state_d     = WIN_IDLE;
                have_prev_d = 1'b1;
                prev_idx_d  = best_idx_d;
            end
            if (in_last) begin
                have_prev_d = 1'b0;
            end
        end
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= WIN_IDLE;
            end_q       <= '0;
            best_idx_q  <= '0;
            best_prof_q <= '0;
            have_prev_q <= 1'b0;
            prev_idx_q  <= '0;
        end else begin
            state_q     <= state_d;
            end_q       <= end_d;
            best_idx_q  <= best_idx_d;
            best_prof_q <= best_prof_d;
            have_prev_q <= have_prev_d;
            prev_idx_q  <= prev_idx_d;
        end
    end

    // Output registers: one-cycle pulse carrying the chosen point
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_q  <= 1'b0;
            out_idx_q    <= '0;
            out_profit_q <= '0;
        end else begin
            out_valid_q <= emit;
            if (emit) begin
                out_idx_q    <= best_idx_d;
                out_profit_q <= best_prof_d;
            end
        end
    end

    assign out_valid  = out_valid_q;
    assign out_idx    = out_idx_q;
    assign out_profit = out_profit_q;

endmodule

// File: rtl/phase_boundary_detect.sv
// Module: phase_boundary_detect
// Top level: turns a stream of per-interval normalized miss-count pairs
// into spaced, best-in-window reconfiguration points.
// Assumes normalization is done upstream and one record per interval.
module phase_boundary_detect #(
    parameter int CNT_W   = 16,
    parameter int IDX_W   = 16,
    parameter int SPACING = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rec_valid,
    input  logic [CNT_W-1:0] rec_miss_a,
    input  logic [CNT_W-1:0] rec_miss_b,
    input  logic             rec_last,
    input  logic [CNT_W-1:0] thresh,
    output logic             pt_valid,
    output logic [IDX_W-1:0] pt_index,
    output logic [CNT_W-1:0] pt_profit
);

    logic [CNT_W-1:0] profit;
    logic             hit;
    logic [IDX_W-1:0] cur_idx;

    pbd_absdiff #(.CNT_W(CNT_W)) u_absdiff (
        .cnt_a     (rec_miss_a),
        .cnt_b     (rec_miss_b),
        .limit     (thresh),
        .magnitude (profit),
        .over      (hit)
    );

    pbd_interval_ctr #(.IDX_W(IDX_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (rec_valid),
        .restart (rec_last),
        .cur_idx (cur_idx)
    );

    pbd_window_sel #(
        .IDX_W   (IDX_W),
        .CNT_W   (CNT_W),
        .SPACING (SPACING)
    ) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (rec_valid),
        .in_last    (rec_last),
        .in_idx     (cur_idx),
        .in_profit  (profit),
        .in_hit     (hit),
        .out_valid  (pt_valid),
        .out_idx    (pt_index),
        .out_profit (pt_profit)
    );

endmodule

// File: rtl/phase_boundary_detect_chk.sv
// Module: phase_boundary_detect_chk
// Checker bound to the top level: observes its ports only.
// Assumes the same parameters as the bound instance.
module phase_boundary_detect_chk #(
    parameter int CNT_W   = 16,
    parameter int IDX_W   = 16,
    parameter int SPACING = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rec_valid,
    input logic             rec_last,
    input logic             pt_valid,
    input logic [IDX_W-1:0] pt_index,
    input logic [CNT_W-1:0] pt_profit
);

    logic             seen_pt;
    logic [IDX_W-1:0] last_pt;
    logic             run_end;

    // Remember the previous point of the run and whether the run just ended
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_pt <= 1'b0;
            last_pt <= '0;
            run_end <= 1'b0;
        end else begin
            run_end <= rec_valid && rec_last;
            if (pt_valid) begin
                last_pt <= pt_index;
            end
            if (run_end) begin
                seen_pt <= 1'b0;
            end else if (pt_valid) begin
                seen_pt <= 1'b1;
            end
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !pt_valid);

    // R3: a point always has profitability above some threshold, so never zero
    assert_nonzero_profit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pt_valid |-> (pt_profit != '0));

    assert_after_record_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pt_valid |-> $past(rec_valid));

    assert_min_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_valid && seen_pt) |-> ((pt_index - last_pt) >= IDX_W'(SPACING)));

endmodule

bind phase_boundary_detect phase_boundary_detect_chk #(
    .CNT_W   (CNT_W),
    .IDX_W   (IDX_W),
    .SPACING (SPACING)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rec_valid (rec_valid),
    .rec_last  (rec_last),
    .pt_valid  (pt_valid),
    .pt_index  (pt_index),
    .pt_profit (pt_profit)
);

// File: tb/tb_phase_boundary_detect.sv
// Bench: directed streams plus a threshold sweep, each cycle compared with
// an arithmetic model of the requirements.
module tb_phase_boundary_detect;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 16;
    localparam int IW = 16;
    localparam int SP = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rec_valid = 1'b0;
    logic [CW-1:0] rec_miss_a = '0;
    logic [CW-1:0] rec_miss_b = '0;
    logic          rec_last = 1'b0;
    logic [CW-1:0] thresh = '0;
    logic          pt_valid;
    logic [IW-1:0] pt_index;
    logic [CW-1:0] pt_profit;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // model state
    int  m_idx = 0;
    bit  m_open = 1'b0;
    int  m_end = 0;
    int  m_bi = 0;
    int  m_bp = 0;
    bit  m_hp = 1'b0;
    int  m_prev = 0;

    phase_boundary_detect #(.CNT_W(CW), .IDX_W(IW), .SPACING(SP)) dut (
        .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid),
        .rec_miss_a(rec_miss_a), .rec_miss_b(rec_miss_b),
        .rec_last(rec_last), .thresh(thresh),
        .pt_valid(pt_valid), .pt_index(pt_index), .pt_profit(pt_profit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input bit ev, input int ei, input int ep);
        checks++;
        if (pt_valid !== ev) begin
            failures++;
            $display("FAIL %s pt_valid actual=%0b expected=%0b", tag, pt_valid, ev);
        end else if (ev && (pt_index !== IW'(ei) || pt_profit !== CW'(ep))) begin
            failures++;
            $display("FAIL %s point actual=(%0d,%0d) expected=(%0d,%0d)",
                     tag, pt_index, pt_profit, ei, ep);
        end
    endtask

    // One record: drive, model, then compare after the edge
    task automatic rec(input int a, input int b, input bit last, input string tag);
        int  prof;
        bit  ev;
        int  ei;
        int  ep;
        @(negedge clk);
        rec_valid  = 1'b1;
        rec_miss_a = CW'(a);
        rec_miss_b = CW'(b);
        rec_last   = last;
        prof = (a > b) ? a - b : b - a;
        ev = 1'b0; ei = 0; ep = 0;
        if (!m_open) begin
            if (prof > int'(thresh) && (!m_hp || m_idx - m_prev >= SP)) begin
                m_open = 1'b1; m_end = m_idx + SP - 1; m_bi = m_idx; m_bp = prof;
            end
        end else if (prof > int'(thresh) && prof > m_bp) begin
            m_bi = m_idx; m_bp = prof;
        end
        if (m_open && (last || m_idx == m_end)) begin
            ev = 1'b1; ei = m_bi; ep = m_bp; m_open = 1'b0; m_hp = 1'b1; m_prev = m_bi;
        end
        if (last) begin
            m_idx = 0; m_hp = 1'b0;
        end else begin
            m_idx++;
        end
        @(posedge clk);
        #1;
        rec_valid = 1'b0;
        rec_last  = 1'b0;
        check(tag, ev, ei, ep);
    endtask

    // Idle cycle: no record, no point expected (R9)
    task automatic idle();
        @(negedge clk);
        rec_valid  = 1'b0;
        rec_miss_a = 16'hFFFF;
        rec_last   = 1'b1;
        @(posedge clk);
        #1;
        rec_last = 1'b0;
        check("R9 idle", 1'b0, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        thresh = 16'd10;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", 1'b0, 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 after release", 1'b0, 0, 0);

        // R3: equal large counts, then at-threshold, then just above
        rec(5000, 5000, 1'b0, "R3 equal");
        rec(9000, 9000, 1'b0, "R3 equal");
        rec(30, 20, 1'b0, "R3 at threshold");
        rec(20, 31, 1'b0, "R3 above opens window");
        rec(0, 0, 1'b0, "R6 window");
        rec(0, 0, 1'b0, "R6 window");
        rec(0, 0, 1'b0, "R6 window");
        rec(0, 0, 1'b0, "R2 R4 R5 close emits idx3 profit11");
        // R7: candidates too close to point 3 are ignored (indices 8..9 are >= 8 actually allowed)
        rec(100, 0, 1'b0, "R7 idx8 eligible opens");
        rec(0, 150, 1'b0, "R6 rising");
        rec(0, 150, 1'b0, "R6 tie keeps earliest");
        rec(40, 0, 1'b0, "R6 lower");
        idle();
        rec(0, 0, 1'b0, "R6 close emits idx9");
        // idx13: within 9+5 -> blocked
        rec(500, 0, 1'b0, "R7 blocked idx13");
        rec(0, 0, 1'b0, "R7");
        rec(60, 0, 1'b0, "R7 idx15 blocked? no, eligible");
        rec(70, 0, 1'b1, "R8 last flushes window");
        // new run restarts at index 0 with no spacing history
        rec(0, 90, 1'b0, "R4 R8 restart idx0");
        rec(0, 0, 1'b1, "R8 last closes early");
        rec(44, 0, 1'b1, "R8 lone candidate last");
        idle();

        // Sweep: three thresholds, pseudo-random small counts with gaps
        lfsr = 16'hACE1;
        for (int t = 0; t < 3; t++) begin
            thresh = CW'(t * 4 + 1);
            for (int n = 0; n < 150; n++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                if (lfsr[11:9] == 3'd0) idle();
                rec(int'(lfsr[3:0]), int'(lfsr[7:4]), n == 149, "R2 R6 R7 sweep");
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule